// File: doc/BRIEF.md
# PCI configuration port decoder

This block is the host-side decoder for the classic two-port indirect scheme used to reach PCI configuration space from x86 I/O cycles. A 32-bit selector register sits at one I/O port and a four-byte data window sits at the next four ports. Software first writes a selector that holds an enable bit, a bus number, a device/function index and a dword-aligned register number. It then reads or writes the window. The block checks that the selector targets bus 0 with the enable bit set. It also checks that a handler exists for the selected device/function. It then forwards the access to a single downstream configuration-space port, or it answers with all-ones.

Each I/O access is presented as a one-cycle strobe with port, byte count and write data. Every accepted access finishes with a one-cycle completion pulse, which carries read data and an error flag. Accesses that need the downstream port keep the block busy until the target has taken the request and, for reads, returned data. A separate registration port sets or clears the presence bit of each device/function. A data shadow register keeps the last value moved through the window and is visible on an output.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset the selector and the data shadow are zero, every presence bit is clear, and io_done, io_err, io_busy and cfg_valid are low.
- R2: A 4-byte write at the selector port (default 0xCF8) stores the full 32-bit value, and a 4-byte read there returns the stored value. A selector access of any other byte count does not change the selector.
- R3: A window access is valid only when the selector ANDed with 0x80FF0000 equals 0x80000000, that is bit 31 set and bus bits 23:16 zero. An invalid window read returns 0xFFFFFFFF, and an invalid window write is not forwarded.
- R4: A forwarded request carries the device/function index from selector bits 15:8 and an 8-bit offset of (selector bits 7:2 times 4) plus port bits 1:0. It also carries the access byte count (1 to 4) and, for writes, the unshifted write data.
- R5: The presence table has one bit per device/function, written through the registration port (fn_set, fn_idx, fn_val). A window read to a device/function whose bit is clear returns 0xFFFFFFFF and is not forwarded.
- R6: A valid window write is forwarded only when its offset is 4 to 7, 12, 13 or greater than 14. Writes to other offsets complete without being forwarded.
- R7: The data shadow takes the value returned by every window read, all-ones answers included. On a forwarded write it takes the write data shifted left by 8 times port bits 1:0. Dropped or invalid writes leave it unchanged.
- R8: cfg_valid and its request fields stay stable until cfg_ready is sampled high, and io_busy is high for that whole time. A forwarded read completes in the cycle after cfg_rvalid, with io_rdata equal to the returned cfg_rdata.
- R9: An access to a port outside the selector and the window, a selector access that is not 4 bytes, or a window access with a byte count outside 1 to 4 completes with io_err high and changes neither the selector nor the shadow.
- R10: Every accepted access that is not forwarded completes with io_done in the cycle after the strobe. A forwarded write completes in the cycle after cfg_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | One-cycle I/O access strobe, taken when io_busy is low |
| io_we | input | 1 | 1 = write, 0 = read |
| io_port | input | 16 | I/O port address |
| io_len | input | 3 | Byte count of the access |
| io_wdata | input | 32 | Write data |
| io_done | output | 1 | Completion pulse |
| io_err | output | 1 | Unsupported access, valid with io_done |
| io_busy | output | 1 | A forwarded access is in progress |
| io_rdata | output | 32 | Read data, valid with io_done on reads |
| fn_set | input | 1 | Presence table write strobe |
| fn_idx | input | 8 | Device/function index to update |
| fn_val | input | 1 | New presence bit |
| cfg_valid | output | 1 | Downstream request valid |
| cfg_ready | input | 1 | Downstream request accepted |
| cfg_we | output | 1 | Downstream request is a write |
| cfg_dev | output | 8 | Device/function index |
| cfg_off | output | 8 | Register offset |
| cfg_len | output | 3 | Byte count |
| cfg_wdata | output | 32 | Write data |
| cfg_rvalid | input | 1 | Downstream read data valid |
| cfg_rdata | input | 32 | Downstream read data |
| data_shadow | output | 32 | Last data moved through the window |

## Verification
The bench aims at the selector mask edges: enable bit clear, and a bus number of 1 with everything else valid. A decoder that tests only bit 31 would forward the bus-1 case. It also aims at the write-filter boundaries at offsets 3, 12, 14 and 15 when reached through byte lanes. A filter keyed on the aligned register instead of the lane-adjusted offset would let offset 14 through or block offset 15. The shadow is checked after all-ones answers and after lane-shifted writes, where a missing shift or a capture on dropped writes shows up at once. Presence bits are set and then cleared again, so a table that cannot clear keeps forwarding to a vanished handler.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;

    localparam int unsigned CFG_DW   = 32;
    localparam int unsigned CFG_PW   = 16;
    localparam int unsigned CFG_FNW  = 8;
    localparam int unsigned CFG_OW   = 8;
    localparam int unsigned CFG_LW   = 3;
    localparam int unsigned CFG_LANW = 2;

    localparam logic [CFG_DW-1:0] WIN_MASK  = 32'h80FF_0000;
    localparam logic [CFG_DW-1:0] WIN_MATCH = 32'h8000_0000;
    localparam logic [CFG_LW-1:0] DWORD_LEN = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } seq_e;

    typedef enum logic [1:0] {
        PC_SEL   = 2'd0,
        PC_WIN   = 2'd1,
        PC_OTHER = 2'd2
    } pclass_e;

    typedef struct packed {
        seq_e                 st;
        logic [CFG_DW-1:0]    sel;
        logic [CFG_DW-1:0]    shadow;
        logic                 done;
        logic                 err;
        logic [CFG_DW-1:0]    rdata;
        logic                 fwe;
        logic [CFG_FNW-1:0]   fdev;
        logic [CFG_OW-1:0]    foff;
        logic [CFG_LW-1:0]    flen;
        logic [CFG_LANW-1:0]  flane;
        logic [CFG_DW-1:0]    fwdata;
    } dec_state_t;

    // Offsets a window write may reach: 4..7, 12, 13 and everything above 14.
    function automatic logic wr_open(input logic [CFG_OW-1:0] off);
        return ((off >= 8'd4) && (off <= 8'd7)) || (off == 8'd12) ||
               (off == 8'd13) || (off > 8'd14);
    endfunction

endpackage

// File: rtl/cfgdec_fn_table.sv
module cfgdec_fn_table #(
    parameter int unsigned NFN = 256,
    localparam int unsigned IW = $clog2(NFN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    input  logic          set_val,
    input  logic [IW-1:0] look_idx,
    output logic          look_hit
);

    logic [NFN-1:0] ent_d;
    logic [NFN-1:0] ent_q;

    for (genvar i = 0; i < NFN; i++) begin : g_ent
        assign ent_d[i] = (set_en && (set_idx == IW'(i))) ? set_val : ent_q[i];

        always_ff @(posedge clk) begin
            if (!rst_n) ent_q[i] <= 1'b0;
            else        ent_q[i] <= ent_d[i];
        end
    end

    assign look_hit = ent_q[look_idx];

endmodule

// File: rtl/cfgdec_addr_decode.sv
module cfgdec_addr_decode
    import cfgdec_pkg::*;
#(
    parameter logic [CFG_PW-1:0] SEL_PORT = 16'h0CF8,
    localparam logic [CFG_PW-1:0] WIN_PORT = SEL_PORT + 16'd4
) (
    input  logic [CFG_PW-1:0]   io_port,
    input  logic [CFG_LW-1:0]   io_len,
    input  logic [CFG_DW-1:0]   sel,
    output pclass_e             pclass,
    output logic                len_ok,
    output logic                dword,
    output logic                win_ok,
    output logic [CFG_FNW-1:0]  fn_idx,
    output logic [CFG_OW-1:0]   reg_off,
    output logic [CFG_LANW-1:0] lane
);

    always_comb begin
        if (io_port == SEL_PORT)
            pclass = PC_SEL;
        else if (io_port[CFG_PW-1:CFG_LANW] == WIN_PORT[CFG_PW-1:CFG_LANW])
            pclass = PC_WIN;
        else
            pclass = PC_OTHER;
    end

    assign len_ok  = (io_len != '0) && (io_len <= DWORD_LEN);
    assign dword   = (io_len == DWORD_LEN);
    assign win_ok  = ((sel & WIN_MASK) == WIN_MATCH);
    assign fn_idx  = sel[15:8];
    assign lane    = io_port[CFG_LANW-1:0];
    assign reg_off = {sel[7:2], 2'b00} + {6'd0, lane};

endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
    import cfgdec_pkg::*;
#(
    parameter logic [CFG_PW-1:0] SEL_PORT = 16'h0CF8,
    localparam int unsigned NUM_FN = 1 << CFG_FNW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                io_req,
    input  logic                io_we,
    input  logic [CFG_PW-1:0]   io_port,
    input  logic [CFG_LW-1:0]   io_len,
    input  logic [CFG_DW-1:0]   io_wdata,
    output logic                io_done,
    output logic                io_err,
    output logic                io_busy,
    output logic [CFG_DW-1:0]   io_rdata,
    input  logic                fn_set,
    input  logic [CFG_FNW-1:0]  fn_idx,
    input  logic                fn_val,
    output logic                cfg_valid,
    input  logic                cfg_ready,
    output logic                cfg_we,
    output logic [CFG_FNW-1:0]  cfg_dev,
    output logic [CFG_OW-1:0]   cfg_off,
    output logic [CFG_LW-1:0]   cfg_len,
    output logic [CFG_DW-1:0]   cfg_wdata,
    input  logic                cfg_rvalid,
    input  logic [CFG_DW-1:0]   cfg_rdata,
    output logic [CFG_DW-1:0]   data_shadow
);

    dec_state_t d, q;

    pclass_e              pclass;
    logic                 len_ok;
    logic                 dword;
    logic                 win_ok;
    logic [CFG_FNW-1:0]   sel_fn;
    logic [CFG_OW-1:0]    sel_off;
    logic [CFG_LANW-1:0]  lane;
    logic                 fn_hit;
    logic [CFG_DW-1:0]    sel_latch;

    assign sel_latch = q.sel;

    cfgdec_addr_decode #(
        .SEL_PORT (SEL_PORT)
    ) u_dec (
        .io_port (io_port),
        .io_len  (io_len),
        .sel     (q.sel),
        .pclass  (pclass),
        .len_ok  (len_ok),
        .dword   (dword),
        .win_ok  (win_ok),
        .fn_idx  (sel_fn),
        .reg_off (sel_off),
        .lane    (lane)
    );

    cfgdec_fn_table #(
        .NFN (NUM_FN)
    ) u_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (fn_set),
        .set_idx  (fn_idx),
        .set_val  (fn_val),
        .look_idx (sel_fn),
        .look_hit (fn_hit)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (io_req) begin
                    d.done = 1'b1;
                    unique case (pclass)
                        PC_SEL: begin
                            if (!dword)     d.err   = 1'b1;
                            else if (io_we) d.sel   = io_wdata;
                            else            d.rdata = q.sel;
                        end
                        PC_WIN: begin
                            if (!len_ok) begin
                                d.err = 1'b1;
                            end else if (!win_ok || !fn_hit) begin
                                if (!io_we) begin
                                    d.rdata  = '1;
                                    d.shadow = '1;
                                end
                            end else if (!io_we || wr_open(sel_off)) begin
                                d.done   = 1'b0;
                                d.st     = ST_REQ;
                                d.fwe    = io_we;
                                d.fdev   = sel_fn;
                                d.foff   = sel_off;
                                d.flen   = io_len;
                                d.flane  = lane;
                                d.fwdata = io_wdata;
                            end
                        end
                        default: d.err = 1'b1;
                    endcase
                end
            end
            ST_REQ: begin
                if (cfg_ready) begin
                    if (q.fwe) begin
                        d.st     = ST_IDLE;
                        d.done   = 1'b1;
                        d.shadow = q.fwdata << {q.flane, 3'b000};
                    end else begin
                        d.st = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (cfg_rvalid) begin
                    d.st     = ST_IDLE;
                    d.done   = 1'b1;
                    d.rdata  = cfg_rdata;
                    d.shadow = cfg_rdata;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign io_done     = q.done;
    assign io_err      = q.err;
    assign io_busy     = (q.st != ST_IDLE);
    assign io_rdata    = q.rdata;
    assign cfg_valid   = (q.st == ST_REQ);
    assign cfg_we      = q.fwe;
    assign cfg_dev     = q.fdev;
    assign cfg_off     = q.foff;
    assign cfg_len     = q.flen;
    assign cfg_wdata   = q.fwdata;
    assign data_shadow = q.shadow;

endmodule

// File: rtl/cfgdec_checker.sv
module cfgdec_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        io_done,
    input logic        io_err,
    input logic        io_busy,
    input logic [31:0] io_rdata,
    input logic        cfg_valid,
    input logic        cfg_ready,
    input logic        cfg_we,
    input logic [7:0]  cfg_dev,
    input logic [7:0]  cfg_off,
    input logic [2:0]  cfg_len,
    input logic [31:0] cfg_wdata,
    input logic        cfg_rvalid,
    input logic [31:0] cfg_rdata,
    input logic [31:0] sel_latch,
    input logic        fn_hit
);

    AST_WIN_BUS0: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (sel_latch[31] && (sel_latch[23:16] == 8'd0))); // R3

    AST_DEV_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (cfg_dev == sel_latch[15:8])); // R4

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> ((cfg_len != 3'd0) && (cfg_len <= 3'd4))); // R4

    AST_FWD_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> fn_hit); // R5

    AST_WR_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_we) |-> (((cfg_off >= 8'd4) && (cfg_off <= 8'd7)) ||
            (cfg_off == 8'd12) || (cfg_off == 8'd13) || (cfg_off > 8'd14))); // R6

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_off) &&
            $stable(cfg_dev) && $stable(cfg_wdata) && $stable(cfg_we))); // R8

    AST_BUSY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> io_busy); // R8

    AST_READ_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (io_busy && !cfg_valid && cfg_rvalid) |=>
            (io_done && (io_rdata == $past(cfg_rdata)))); // R8

    AST_ERR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        io_err |-> io_done); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        io_done |-> !io_busy); // R10

endmodule

bind cfg_port_decoder cfgdec_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_done    (io_done),
    .io_err     (io_err),
    .io_busy    (io_busy),
    .io_rdata   (io_rdata),
    .cfg_valid  (cfg_valid),
    .cfg_ready  (cfg_ready),
    .cfg_we     (cfg_we),
    .cfg_dev    (cfg_dev),
    .cfg_off    (cfg_off),
    .cfg_len    (cfg_len),
    .cfg_wdata  (cfg_wdata),
    .cfg_rvalid (cfg_rvalid),
    .cfg_rdata  (cfg_rdata),
    .sel_latch  (sel_latch),
    .fn_hit     (fn_hit)
);

// File: tb/cfg_port_decoder_test.sv
module cfg_port_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req = 1'b0, io_we = 1'b0;
    logic [15:0] io_port = '0;
    logic [2:0]  io_len = '0;
    logic [31:0] io_wdata = '0;
    logic        io_done, io_err, io_busy;
    logic [31:0] io_rdata;
    logic        fn_set = 1'b0, fn_val = 1'b0;
    logic [7:0]  fn_idx = '0;
    logic        cfg_valid, cfg_we;
    logic        cfg_ready = 1'b0, cfg_rvalid = 1'b0;
    logic [7:0]  cfg_dev, cfg_off;
    logic [2:0]  cfg_len;
    logic [31:0] cfg_wdata, cfg_rdata = '0, data_shadow;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    cfg_port_decoder uut (
        .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_we(io_we), .io_port(io_port),
        .io_len(io_len), .io_wdata(io_wdata), .io_done(io_done), .io_err(io_err),
        .io_busy(io_busy), .io_rdata(io_rdata), .fn_set(fn_set), .fn_idx(fn_idx),
        .fn_val(fn_val), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_we(cfg_we),
        .cfg_dev(cfg_dev), .cfg_off(cfg_off), .cfg_len(cfg_len), .cfg_wdata(cfg_wdata),
        .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata), .data_shadow(data_shadow)
    );

    // reference state
    logic [31:0]  ref_sel = '0;
    logic [31:0]  ref_shadow = '0;
    logic [255:0] ref_tab = '0;

    // what the target saw
    logic        fw_seen = 1'b0, fw_we = 1'b0;
    logic [7:0]  fw_dev = '0, fw_off = '0;
    logic [2:0]  fw_len = '0;
    logic [31:0] fw_wdata = '0;
    logic        got_err = 1'b0;
    logic [31:0] got_rdata = '0;

    function automatic logic [31:0] tgt_resp(input logic [7:0] dev, input logic [7:0] off);
        return {dev, off, ~dev, off ^ 8'h5A};
    endfunction

    function automatic logic wr_ok(input logic [7:0] off);
        return (off >= 4 && off <= 7) || off == 12 || off == 13 || off > 14;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // downstream target model
    initial begin
        forever begin
            @(negedge clk);
            if (cfg_valid) begin
                chk("R8 busy during request", {31'd0, io_busy}, 32'd1);
                repeat ($urandom % 3) @(negedge clk);
                fw_seen = 1'b1; fw_we = cfg_we; fw_dev = cfg_dev; fw_off = cfg_off;
                fw_len = cfg_len; fw_wdata = cfg_wdata;
                cfg_ready = 1'b1;
                @(negedge clk);
                cfg_ready = 1'b0;
                if (!fw_we) begin
                    repeat ($urandom % 3) @(negedge clk);
                    cfg_rdata = tgt_resp(fw_dev, fw_off);
                    cfg_rvalid = 1'b1;
                    @(negedge clk);
                    cfg_rvalid = 1'b0;
                end
            end
        end
    end

    task automatic do_io(input logic we, input logic [15:0] port, input logic [2:0] len,
                         input logic [31:0] wd);
        int n;
        fw_seen = 1'b0;
        @(negedge clk);
        io_req = 1'b1; io_we = we; io_port = port; io_len = len; io_wdata = wd;
        @(negedge clk);
        io_req = 1'b0;
        n = 0;
        while (!io_done && n < 50) begin
            @(negedge clk);
            n++;
        end
        if (n >= 50) chk("R10 completion timeout", 32'd0, 32'd1);
        got_err = io_err;
        got_rdata = io_rdata;
    endtask

    task automatic sel_write(input logic [31:0] v);
        do_io(1'b1, 16'h0CF8, 3'd4, v);
        chk("R2 selector write no error", {31'd0, got_err}, 32'd0);
        ref_sel = v;
    endtask

    task automatic reg_fn(input logic [7:0] idx, input logic v);
        @(negedge clk);
        fn_set = 1'b1; fn_idx = idx; fn_val = v;
        @(negedge clk);
        fn_set = 1'b0;
        ref_tab[idx] = v;
    endtask

    task automatic win_access(input logic we, input logic [1:0] ln, input logic [2:0] len,
                              input logic [31:0] wd, input string tag);
        logic [7:0] off, dev;
        logic valid, fwd;
        logic [31:0] exp;
        off = {ref_sel[7:2], 2'b00} + {6'd0, ln};
        dev = ref_sel[15:8];
        valid = ref_sel[31] && ref_sel[23:16] == 8'd0 && ref_tab[dev];
        fwd = valid && (!we || wr_ok(off));
        do_io(we, 16'h0CFC | {14'd0, ln}, len, wd);
        chk({tag, " no error"}, {31'd0, got_err}, 32'd0);
        chk({tag, " forwarded"}, {31'd0, fw_seen}, {31'd0, fwd});
        if (fwd && fw_seen) begin
            chk("R4 dev field", {24'd0, fw_dev}, {24'd0, dev});
            chk("R4 offset field", {24'd0, fw_off}, {24'd0, off});
            chk("R4 length field", {29'd0, fw_len}, {29'd0, len});
            chk("R4 direction", {31'd0, fw_we}, {31'd0, we});
            if (we) chk("R4 write data", fw_wdata, wd);
        end
        if (!we) begin
            exp = valid ? tgt_resp(dev, off) : 32'hFFFF_FFFF;
            chk({tag, " read data"}, got_rdata, exp);
            ref_shadow = exp;
        end else if (fwd) begin
            ref_shadow = wd << (8 * ln);
        end
        chk("R7 data shadow", data_shadow, ref_shadow);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h0000_2B17);
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 shadow", data_shadow, 32'd0);
        chk("R1 idle outputs", {28'd0, io_done, io_err, io_busy, cfg_valid}, 32'd0);
        rst_n = 1'b1;
        do_io(1'b0, 16'h0CF8, 3'd4, 32'd0);
        chk("R1 selector zero", got_rdata, 32'd0);

        // R2 selector write and readback, short access rejected
        sel_write(32'h8000_1234);
        do_io(1'b0, 16'h0CF8, 3'd4, 32'd0);
        chk("R2 selector readback", got_rdata, 32'h8000_1234);
        do_io(1'b1, 16'h0CF8, 3'd2, 32'hDEAD_BEEF);
        chk("R9 short selector error", {31'd0, got_err}, 32'd1);
        do_io(1'b0, 16'h0CF8, 3'd4, 32'd0);
        chk("R2 selector unchanged", got_rdata, 32'h8000_1234);

        // R9 bad port and bad length
        do_io(1'b0, 16'h0CF0, 3'd4, 32'd0);
        chk("R9 foreign port error", {31'd0, got_err}, 32'd1);
        do_io(1'b0, 16'h0CFD, 3'd0, 32'd0);
        chk("R9 zero length error", {31'd0, got_err}, 32'd1);
        chk("R9 shadow untouched", data_shadow, 32'd0);

        // R5 unregistered device answers all-ones
        sel_write(32'h8000_0800);
        win_access(1'b0, 2'd0, 3'd4, 32'd0, "R5 absent read");
        reg_fn(8'h08, 1'b1);
        win_access(1'b0, 2'd2, 3'd2, 32'd0, "R5 present read");

        // R3 enable bit clear and bus 1
        sel_write(32'h0000_0800);
        win_access(1'b0, 2'd0, 3'd4, 32'd0, "R3 disabled read");
        sel_write(32'h8001_0800);
        win_access(1'b0, 2'd1, 3'd1, 32'd0, "R3 bus1 read");
        win_access(1'b1, 2'd0, 3'd4, 32'h1111_2222, "R3 bus1 write");

        // R6 write filter boundaries, R7 lane shift
        sel_write(32'h8000_0800);
        win_access(1'b1, 2'd0, 3'd4, 32'hA1A2_A3A4, "R6 offset 0");
        win_access(1'b1, 2'd3, 3'd1, 32'h0000_00B3, "R6 offset 3");
        sel_write(32'h8000_0804);
        win_access(1'b1, 2'd1, 3'd2, 32'h0000_C0C1, "R6 offset 5");
        sel_write(32'h8000_080C);
        win_access(1'b1, 2'd0, 3'd1, 32'h0000_0055, "R6 offset 12");
        win_access(1'b1, 2'd2, 3'd1, 32'h0000_0066, "R6 offset 14");
        win_access(1'b1, 2'd3, 3'd1, 32'h0000_0077, "R6 offset 15");

        // R5 clearing a presence bit
        reg_fn(8'h08, 1'b0);
        win_access(1'b0, 2'd0, 3'd4, 32'd0, "R5 cleared read");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom % 5;
            if (op == 0) begin
                logic [31:0] v;
                v = $urandom;
                v[31] = ($urandom % 8) != 0;
                v[23:16] = (($urandom % 6) == 0) ? 8'd1 : 8'd0;
                v[15:8] = 8'($urandom % 32);
                sel_write(v);
                do_io(1'b0, 16'h0CF8, 3'd4, 32'd0);
                chk("R2 random readback", got_rdata, ref_sel);
            end else if (op == 1) begin
                reg_fn(8'($urandom % 32), 1'($urandom % 4 != 0));
            end else begin
                win_access(op == 2, 2'($urandom), 3'(1 + $urandom % 4), $urandom,
                           op == 2 ? "R6 random write" : "R3 random read");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule